// File: doc/BRIEF.md
# Monochrome to colour expander

This block turns packed one-bit-per-pixel source data into full colour pixels for a destination rectangle. It is meant for drawing glyphs, two-colour patterns such as checkerboards, and similar stencil-like images. Every source bit becomes one output pixel. A cleared bit produces the background colour and a set bit produces the foreground colour. The raw bit travels with the pixel as a mask, so a later raster-operation stage can still tell foreground from background.

Source words come from one of two places, chosen when the operation starts. The first is a streamed word sequence with a valid/ready handshake and an end-of-stream indication. The second is a memory-fetch port that sends one word address at a time and waits for an acknowledge. The work is sized only from the destination width, height and, in memory mode, a rectangle count. There is no source size anywhere in the block. In stream mode a single rectangle is drawn, whatever count is supplied. If the stream runs dry before the rectangle is finished, an underflow flag is raised and the missing pixels are filled in.

Top module: `mono_expand`

## Requirements
- R1: After reset, pixValid, memReq, strmReady, done and underflow are all 0.
- R2: A source bit of 0 yields pixData equal to colorBg with pixMask 0. A source bit of 1 yields colorFg with pixMask 1. Both colours are captured when start is accepted.
- R3: Bits are taken from each WORD_W-bit word starting at bit 0 and moving upward. Every destination row begins with a newly fetched word, and the unused high bits of a row's last word are discarded. A row of width W therefore uses ceil(W/WORD_W) words.
- R4: One rectangle produces exactly rectW*rectH pixels, in raster order: left to right within a row, rows from top to bottom.
- R5: In memory mode (srcStream=0), rectCount rectangles are drawn back to back. The word addresses are memBase, memBase+1, … with no gaps. memReq stays high with a stable address until memAck is seen, and memReq and strmReady are never high together.
- R6: In stream mode (srcStream=1), exactly one rectangle is drawn whatever rectCount holds. Exactly ceil(rectW/WORD_W)*rectH words are accepted, and words beyond that are left in the stream.
- R7: In stream mode, if a word is needed while strmEnd=1 and strmValid=0, underflow goes to 1. All remaining pixels are then colorBg with pixMask 0, and no further words are accepted. underflow stays set until the next accepted start clears it.
- R8: done is a one-cycle pulse in the cycle after the handshake of the last pixel of the last rectangle. If rectW or rectH is 0, or rectCount is 0 in memory mode, no pixel is produced and done pulses in the cycle after start.
- R9: A start that arrives while an operation is in progress is ignored. The running operation finishes with its original settings.
- R10: While pixValid=1 and pixReady=0, the next cycle keeps pixValid=1 with the same pixData and pixMask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when the block is idle |
| srcStream | input | 1 | 1 selects the word stream, 0 selects memory fetch |
| rectW | input | DIM_W | Destination width in pixels |
| rectH | input | DIM_W | Destination height in rows |
| rectCount | input | CNT_W | Number of rectangles (memory mode only) |
| colorBg | input | COLOR_W | Colour for source bit 0 |
| colorFg | input | COLOR_W | Colour for source bit 1 |
| memBase | input | ADDR_W | First word address in memory mode |
| memReq | output | 1 | Word fetch request |
| memAddr | output | ADDR_W | Word address of the request |
| memAck | input | 1 | Fetch acknowledge; memData is valid with it |
| memData | input | WORD_W | Fetched source word |
| strmValid | input | 1 | Stream word valid |
| strmReady | output | 1 | Stream word accepted when both are high |
| strmData | input | WORD_W | Stream source word |
| strmEnd | input | 1 | The stream holds no more words |
| pixValid | output | 1 | Output pixel valid |
| pixReady | input | 1 | Downstream accepts the pixel |
| pixData | output | COLOR_W | Expanded colour |
| pixMask | output | 1 | Raw source bit of this pixel |
| done | output | 1 | Operation-complete pulse |
| underflow | output | 1 | Stream ran out before the rectangle was complete |

## Verification
The hardest situation to reach is a stream that runs out partway through a row, at a moment when the unit is waiting for a word and no valid word is present. Reaching it needs the short stream, the throttled valid and the word fetch to line up in that order. The bench gets there by loading streams that are deliberately shorter than the rectangle needs. It also drops strmValid at random, which lets the unit sit in its fetch wait before strmEnd appears. Random backpressure on pixReady and random delays on memAck stretch every operation. This spreads the ignored mid-operation starts across fetch waits and stalled pixels alike.

// File: rtl/mono_expand_pkg.sv
package mono_expand_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // latch colours and source select
    logic loadWord;  // take the selected incoming word
    logic loadZero;  // take an all-zero padding word
    logic shift;     // advance to the next source bit
  } dpCtlT;
endpackage

// File: rtl/mono_expand_ctrl.sv
module mono_expand_ctrl
  import mono_expand_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIM_W  = 12,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              srcStream,
  input  logic [DIM_W-1:0]  rectW,
  input  logic [DIM_W-1:0]  rectH,
  input  logic [CNT_W-1:0]  rectCount,
  input  logic [ADDR_W-1:0] memBase,
  input  logic              memAck,
  input  logic              strmValid,
  input  logic              strmEnd,
  input  logic              pixReady,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              strmReady,
  output logic              pixValid,
  output logic              done,
  output logic              underflow,
  output dpCtlT             ctl
);
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  typedef enum logic [1:0] {IDLE, FETCH, EMIT} stateT;

  stateT             state;
  logic              modeQ, ufQ, doneQ;
  logic [DIM_W-1:0]  wQ, hQ, col, row;
  logic [CNT_W-1:0]  nQ, rect;
  logic [BIT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] addrQ;
  logic              pixFire, lastCol, lastRow, lastRect, emptyJob;

  assign lastCol  = (col == wQ - 1'b1);
  assign lastRow  = (row == hQ - 1'b1);
  assign lastRect = modeQ || (rect == nQ - 1'b1);
  assign emptyJob = (rectW == '0) || (rectH == '0) || (!srcStream && rectCount == '0);

  always_comb begin
    ctl       = '0;
    memReq    = 1'b0;
    strmReady = 1'b0;
    pixValid  = 1'b0;
    pixFire   = 1'b0;
    ctl.capture = (state == IDLE) && start;
    case (state)
      FETCH: begin
        if (modeQ) begin
          if (ufQ) begin
            ctl.loadZero = 1'b1;
          end else begin
            strmReady = 1'b1;
            if (strmValid)    ctl.loadWord = 1'b1;
            else if (strmEnd) ctl.loadZero = 1'b1;
          end
        end else begin
          memReq = 1'b1;
          if (memAck) ctl.loadWord = 1'b1;
        end
      end
      EMIT: begin
        pixValid  = 1'b1;
        pixFire   = pixReady;
        ctl.shift = pixReady;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= IDLE;
      modeQ  <= 1'b0;
      ufQ    <= 1'b0;
      doneQ  <= 1'b0;
      wQ     <= '0;
      hQ     <= '0;
      nQ     <= '0;
      col    <= '0;
      row    <= '0;
      rect   <= '0;
      bitCnt <= '0;
      addrQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        IDLE: if (start) begin
          modeQ  <= srcStream;
          wQ     <= rectW;
          hQ     <= rectH;
          nQ     <= rectCount;
          ufQ    <= 1'b0;
          col    <= '0;
          row    <= '0;
          rect   <= '0;
          bitCnt <= '0;
          addrQ  <= memBase;
          if (emptyJob) doneQ <= 1'b1;
          else          state <= FETCH;
        end
        FETCH: begin
          if (ctl.loadWord || ctl.loadZero) state <= EMIT;
          if (ctl.loadWord && !modeQ) addrQ <= addrQ + 1'b1;
          if (modeQ && !ufQ && !strmValid && strmEnd) ufQ <= 1'b1;
        end
        EMIT: if (pixFire) begin
          if (lastCol) begin
            col    <= '0;
            bitCnt <= '0;
            if (lastRow) begin
              row <= '0;
              if (lastRect) begin
                state <= IDLE;
                doneQ <= 1'b1;
              end else begin
                rect  <= rect + 1'b1;
                state <= FETCH;
              end
            end else begin
              row   <= row + 1'b1;
              state <= FETCH;
            end
          end else begin
            col <= col + 1'b1;
            if (bitCnt == BIT_LAST) begin
              bitCnt <= '0;
              state  <= FETCH;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign memAddr   = addrQ;
  assign done      = doneQ;
  assign underflow = ufQ;
endmodule

// File: rtl/mono_expand_dp.sv
module mono_expand_dp
  import mono_expand_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int COLOR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtlT              ctl,
  input  logic               srcStream,
  input  logic [COLOR_W-1:0] colorBg,
  input  logic [COLOR_W-1:0] colorFg,
  input  logic [WORD_W-1:0]  memData,
  input  logic [WORD_W-1:0]  strmData,
  output logic [COLOR_W-1:0] pixData,
  output logic               pixMask
);
  logic               modeQ;
  logic [COLOR_W-1:0] bgQ, fgQ;
  logic [WORD_W-1:0]  wordQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= 1'b0;
      bgQ   <= '0;
      fgQ   <= '0;
      wordQ <= '0;
    end else begin
      if (ctl.capture) begin
        modeQ <= srcStream;
        bgQ   <= colorBg;
        fgQ   <= colorFg;
      end
      if (ctl.loadZero)      wordQ <= '0;
      else if (ctl.loadWord) wordQ <= modeQ ? strmData : memData;
      else if (ctl.shift)    wordQ <= wordQ >> 1;
    end
  end

  assign pixMask = wordQ[0];
  assign pixData = wordQ[0] ? fgQ : bgQ;
endmodule

// File: rtl/mono_expand.sv
module mono_expand
  import mono_expand_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int COLOR_W = 32,
  parameter int DIM_W   = 12,
  parameter int CNT_W   = 8,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               srcStream,
  input  logic [DIM_W-1:0]   rectW,
  input  logic [DIM_W-1:0]   rectH,
  input  logic [CNT_W-1:0]   rectCount,
  input  logic [COLOR_W-1:0] colorBg,
  input  logic [COLOR_W-1:0] colorFg,
  input  logic [ADDR_W-1:0]  memBase,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memAck,
  input  logic [WORD_W-1:0]  memData,
  input  logic               strmValid,
  output logic               strmReady,
  input  logic [WORD_W-1:0]  strmData,
  input  logic               strmEnd,
  output logic               pixValid,
  input  logic               pixReady,
  output logic [COLOR_W-1:0] pixData,
  output logic               pixMask,
  output logic               done,
  output logic               underflow
);
  dpCtlT ctl;

  mono_expand_ctrl #(
    .WORD_W(WORD_W), .DIM_W(DIM_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .srcStream(srcStream),
    .rectW(rectW), .rectH(rectH), .rectCount(rectCount), .memBase(memBase),
    .memAck(memAck), .strmValid(strmValid), .strmEnd(strmEnd), .pixReady(pixReady),
    .memReq(memReq), .memAddr(memAddr), .strmReady(strmReady), .pixValid(pixValid),
    .done(done), .underflow(underflow), .ctl(ctl)
  );

  mono_expand_dp #(
    .WORD_W(WORD_W), .COLOR_W(COLOR_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .srcStream(srcStream),
    .colorBg(colorBg), .colorFg(colorFg), .memData(memData), .strmData(strmData),
    .pixData(pixData), .pixMask(pixMask)
  );
endmodule

// File: rtl/mono_expand_chk.sv
module mono_expand_chk #(
  parameter int COLOR_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               pixValid,
  input logic               pixReady,
  input logic [COLOR_W-1:0] pixData,
  input logic               pixMask,
  input logic               done,
  input logic               underflow,
  input logic               memReq,
  input logic               strmReady
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && !pixReady |=> pixValid && $stable(pixData) && $stable(pixMask)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !pixValid && !memReq && !strmReady); // R8

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && strmReady)); // R5

  AST_UF_FROM_STREAM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underflow) |-> $past(strmReady)); // R7

  AST_FETCH_BEFORE_PIX: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || strmReady) |-> !pixValid); // R3
endmodule

bind mono_expand mono_expand_chk #(.COLOR_W(COLOR_W)) uChk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixReady(pixReady),
  .pixData(pixData), .pixMask(pixMask), .done(done), .underflow(underflow),
  .memReq(memReq), .strmReady(strmReady)
);

// File: tb/sim_mono_expand.sv
`timescale 1ns/1ps
module sim_mono_expand;
  localparam int WORD_W = 32, COLOR_W = 32, DIM_W = 12, CNT_W = 8, ADDR_W = 16;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, srcStream = 1'b0;
  logic [DIM_W-1:0] rectW = '0, rectH = '0;
  logic [CNT_W-1:0] rectCount = '0;
  logic [COLOR_W-1:0] colorBg = '0, colorFg = '0;
  logic [ADDR_W-1:0] memBase = '0, memAddr;
  logic memReq, memAck = 1'b0, strmValid = 1'b0, strmReady, strmEnd = 1'b0;
  logic [WORD_W-1:0] memData = '0, strmData = '0;
  logic pixValid, pixReady = 1'b0, pixMask, done, underflow;
  logic [COLOR_W-1:0] pixData;

  mono_expand u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mem [256];
  logic [31:0] strm [64];
  int sIdx = 0, sLen = 0, ackCnt = 0, gotN = 0, doneCnt = 0, doneAt = 0;
  logic [ADDR_W-1:0] baseQ;
  logic [COLOR_W-1:0] gotData [4096];
  logic gotMask [4096];
  logic prevStall = 1'b0, prevMask = 1'b0;
  logic [COLOR_W-1:0] prevData = '0;
  logic active = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    pixReady  = ($urandom % 4) != 0;
    memAck    = memReq && (($urandom % 3) != 0);
    memData   = mem[memAddr[7:0]];
    strmEnd   = sIdx >= sLen;
    strmValid = (sIdx < sLen) && (($urandom % 4) != 0);
    strmData  = strmValid ? strm[sIdx] : 32'hA5A5_5A5A;
    #1;
    if (active) begin
      if (memAck) begin
        chk(memAddr == baseQ + ADDR_W'(ackCnt), "R5 address", 64'(memAddr), 64'(baseQ + ADDR_W'(ackCnt)));
        ackCnt++;
      end
      if (strmValid && strmReady) sIdx++;
      if (prevStall)
        chk(pixValid && pixData == prevData && pixMask == prevMask, "R10 hold",
            {31'd0, pixValid, pixData}, {31'd0, 1'b1, prevData});
      prevStall = pixValid && !pixReady;
      prevData  = pixData;
      prevMask  = pixMask;
      if (pixValid && pixReady && gotN < 4096) begin
        gotData[gotN] = pixData;
        gotMask[gotN] = pixMask;
        gotN++;
      end
      if (done) begin
        doneCnt++;
        doneAt = gotN;
      end
    end
  end

  // Expected source bit: 0/1, or 2 for padding after the stream ends
  function automatic int expBit(bit strMode, int w, int h, int r, int y, int x);
    int wpr = (w + WORD_W - 1) / WORD_W;
    int idx = (r * h + y) * wpr + x / WORD_W;
    logic [31:0] word;
    if (strMode) begin
      if (idx >= sLen) return 2;
      word = strm[idx];
    end else begin
      word = mem[(int'(baseQ) + idx) % 256];
    end
    return int'(word[x % WORD_W]);
  endfunction

  task automatic runOp(input bit strMode, input int w, input int h, input int n,
                       input int slen, input bit busyPoke, input string tag);
    int rects, nWords, expPix, k, wpr;
    bit expUf;
    logic [COLOR_W-1:0] bg, fg;
    bg = $urandom; fg = $urandom;
    @(negedge clk);
    srcStream = strMode; rectW = DIM_W'(w); rectH = DIM_W'(h); rectCount = CNT_W'(n);
    colorBg = bg; colorFg = fg; memBase = ADDR_W'($urandom % 128); baseQ = memBase;
    for (int i = 0; i < 64; i++) strm[i] = $urandom;
    sIdx = 0; sLen = slen; ackCnt = 0; gotN = 0; doneCnt = 0; doneAt = -1;
    prevStall = 1'b0; active = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rects  = (w == 0 || h == 0) ? 0 : (strMode ? 1 : n);
    wpr    = (w + WORD_W - 1) / WORD_W;
    nWords = rects * h * wpr;
    expPix = rects * w * h;
    expUf  = strMode && rects > 0 && nWords > slen;
    if (busyPoke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; srcStream = ~strMode; rectW = DIM_W'(w + 5); rectH = DIM_W'(h + 1);
      colorBg = ~bg; colorFg = ~fg; rectCount = CNT_W'(n + 2);
      @(negedge clk);
      start = 1'b0;
    end
    k = 0;
    while (doneCnt == 0 && k < 5000) begin @(negedge clk); k++; end
    if (doneCnt == 0) begin
      errors++;
      $display("FAIL %s watchdog actual=no done expected=done", tag);
    end
    repeat (3) @(negedge clk);
    #2;
    active = 1'b0;
    chk(doneCnt == 1, "R8 single done", 64'(doneCnt), 64'd1);
    chk(doneAt == expPix, "R8 done after last pixel", 64'(doneAt), 64'(expPix));
    chk(gotN == expPix, "R4 pixel count", 64'(gotN), 64'(expPix));
    chk(underflow == expUf, "R7 underflow flag", 64'(underflow), 64'(expUf));
    if (strMode) chk(sIdx == ((nWords < slen) ? nWords : slen), "R6 words consumed",
                     64'(sIdx), 64'((nWords < slen) ? nWords : slen));
    else         chk(ackCnt == nWords, "R5 fetch count", 64'(ackCnt), 64'(nWords));
    begin
      int bad = 0;
      for (int r = 0; r < rects; r++)
        for (int y = 0; y < h; y++)
          for (int x = 0; x < w; x++) begin
            int idx = (r * h + y) * w + x;
            int b = expBit(strMode, w, h, r, y, x);
            logic [COLOR_W-1:0] ec = (b == 1) ? fg : bg;
            logic em = (b == 1);
            if (idx < gotN && (gotData[idx] != ec || gotMask[idx] != em) && bad < 4) begin
              bad++;
              $display("FAIL R2/R3 %s pixel %0d actual=%0h/%0b expected=%0h/%0b",
                       tag, idx, gotData[idx], gotMask[idx], ec, em);
            end
          end
      checks++;
      if (bad != 0) errors++;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    #1;
    chk(!pixValid && !memReq && !strmReady && !done && !underflow, "R1 reset",
        {59'd0, pixValid, memReq, strmReady, done, underflow}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    runOp(1'b0, 5, 3, 2, 0, 1'b0, "R5 mem small");
    runOp(1'b0, 40, 2, 1, 0, 1'b0, "R3 mem crossing");
    runOp(1'b0, 32, 2, 3, 0, 1'b0, "R3 exact word");
    runOp(1'b1, 33, 2, 3, 10, 1'b0, "R6 stream one rect");
    runOp(1'b1, 10, 4, 1, 2, 1'b0, "R7 underflow");
    runOp(1'b1, 10, 2, 1, 5, 1'b0, "R7 cleared");
    runOp(1'b1, 7, 2, 1, 0, 1'b0, "R7 empty stream");
    runOp(1'b0, 0, 3, 2, 0, 1'b0, "R8 zero width");
    runOp(1'b0, 4, 2, 0, 0, 1'b0, "R8 zero count");
    runOp(1'b0, 20, 3, 2, 0, 1'b1, "R9 mem poke");
    runOp(1'b1, 20, 3, 1, 8, 1'b1, "R9 stream poke");
    for (int t = 0; t < 12; t++) begin
      bit m = $urandom % 2;
      int w = 1 + $urandom % 70;
      int h = 1 + $urandom % 4;
      int need = h * ((w + 31) / 32);
      runOp(m, w, h, 1 + $urandom % 3, ($urandom % 3 == 0) ? need / 2 : need + 1,
            ($urandom % 4) == 0, "R2 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule